// File: doc/BRIEF.md
# Lock Contention Limiter Tracker

This block watches how long threads spend stalled on software locks and, once per measurement interval, names the single thread most likely to sit on the critical path of a parallel program. A critical section whose lock gathers the most waiting is taken to be on that path, so the thread that holds the lock is the one worth speeding up. Each cycle every thread may report that it is waiting and on which lock. The block sums these reports into one waiting total per lock. Separate acquire and release events keep a table of which thread holds which lock.

When the interval tick arrives, the block compares the per-lock totals and picks the largest. It then publishes a one-hot per-thread mask naming the holder of that lock. The mask is meant for a memory request scheduler, which gives that thread's requests priority. The mask is held unchanged until the next tick, and the per-lock totals restart from zero for the new interval.

Top module: `lock_limiter_tracker`

## Requirements
- R1: Each cycle, the total of every lock grows by the number of threads whose wait flag is set with that lock in their lock field. Thread t's lock field is bits [t*LOCK_W +: LOCK_W] of `wait_lock`. The cycle that carries the tick also counts toward the interval that it ends.
- R2: On a tick, the lock with the largest total is chosen. If that total is non-zero and the lock has a holder, the limiter mask becomes a mask with only bit `holder` set.
- R3: When several locks share the largest total, the one with the lowest index is chosen.
- R4: On a tick, the mask becomes all zeros if every total is zero or if the chosen lock has no holder.
- R5: The limiter mask never has more than one bit set. Bit t stands for thread ID t.
- R6: All totals return to zero after a tick, so waiting from an earlier interval never affects a later choice.
- R7: An acquire records the holder thread of its lock and a release clears it. An acquire and a release of the same lock in one cycle leave the lock held by the acquirer. A tick uses the holder table as it stood before that cycle's acquire and release, so a release in the tick cycle still names the releasing thread.
- R8: The mask changes only at the clock edge that samples `tick`. The new value is visible from the next cycle and holds for the whole following interval.
- R9: After reset the mask is zero, no lock has a holder and every total is zero.
- R10: A total stops at 2^ACC_W-1 instead of wrapping. Saturated totals compare as equal, and R3 then applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_valid | input | N_THREADS | Bit t set: thread t is waiting on a lock this cycle |
| wait_lock | input | N_THREADS*LOCK_W | Lock index per thread, thread t at bits [t*LOCK_W +: LOCK_W] |
| acq_valid | input | 1 | A lock is acquired this cycle |
| acq_lock | input | LOCK_W | Index of the acquired lock |
| acq_tid | input | TID_W | Thread that acquires it |
| rel_valid | input | 1 | A lock is released this cycle |
| rel_lock | input | LOCK_W | Index of the released lock |
| tick | input | 1 | Last cycle of the current measurement interval |
| limiter_mask | output | N_THREADS | One-hot-or-zero mask of the limiter thread |

## Verification
The mask is the only result. It is due in the cycle after the clock edge that samples `tick` high, with one register between the tick and the port. The bench drives inputs on the falling edge and advances a behavioural model with the same inputs. It compares the mask on the next falling edge, so each comparison sees exactly one rising edge after its stimulus. Directed intervals give hand-computed masks for ties, unheld winners, release during the tick, clearing and saturation. A long random phase is then compared against the model on every cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam int DEF_THREADS = 4;
    localparam int DEF_LOCKS   = 4;
    localparam int DEF_ACC_W   = 16;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lct_wait_accum.sv
module lct_wait_accum #(
    parameter int N_THREADS = 4,
    parameter int N_LOCKS   = 4,
    parameter int ACC_W     = 16,
    localparam int LOCK_W   = lct_pkg::idx_width(N_LOCKS),
    localparam int CNT_W    = $clog2(N_THREADS + 1),
    localparam int SUM_W    = ACC_W + CNT_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_THREADS-1:0]              wait_valid,
    input  logic [N_THREADS*LOCK_W-1:0]       wait_lock,
    input  logic                              tick,
    output logic [N_LOCKS-1:0][ACC_W-1:0]     total_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    typedef struct packed {
        logic [N_LOCKS-1:0][ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_q, st_d;

    always_comb begin
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        st_d = st_q;
        for (int l = 0; l < N_LOCKS; l++) begin
            cnt = '0;
            for (int t = 0; t < N_THREADS; t++) begin
                if (wait_valid[t] && (wait_lock[t*LOCK_W +: LOCK_W] == LOCK_W'(l)))
                    cnt = cnt + 1'b1;
            end
            sum = SUM_W'(st_q.acc[l]) + SUM_W'(cnt);
            total_o[l]  = (sum > SUM_W'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
            st_d.acc[l] = tick ? '0 : total_o[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_chk
        // R1: within an interval a total never falls
        a_r1_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> st_q.acc[g] >= $past(st_q.acc[g]));
        // R6: a new interval starts from zero
        a_r6_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> st_q.acc[g] == '0);
    end
endmodule

// File: rtl/lct_holder_table.sv
module lct_holder_table #(
    parameter int N_THREADS = 4,
    parameter int N_LOCKS   = 4,
    localparam int LOCK_W   = lct_pkg::idx_width(N_LOCKS),
    localparam int TID_W    = lct_pkg::idx_width(N_THREADS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acq_valid,
    input  logic [LOCK_W-1:0]             acq_lock,
    input  logic [TID_W-1:0]              acq_tid,
    input  logic                          rel_valid,
    input  logic [LOCK_W-1:0]             rel_lock,
    output logic [N_LOCKS-1:0]            held_o,
    output logic [N_LOCKS-1:0][TID_W-1:0] owner_o
);
    typedef struct packed {
        logic [N_LOCKS-1:0]            held;
        logic [N_LOCKS-1:0][TID_W-1:0] owner;
    } hold_state_t;

    hold_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rel_valid)
            st_d.held[rel_lock] = 1'b0;
        if (acq_valid) begin
            st_d.held[acq_lock]  = 1'b1;
            st_d.owner[acq_lock] = acq_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o  = st_q.held;
    assign owner_o = st_q.owner;

    // R7: an acquire always leaves its lock held by the acquirer
    a_r7_acquire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acq_valid |=> held_o[$past(acq_lock)] && (owner_o[$past(acq_lock)] == $past(acq_tid)));
    // R7: a release with no competing acquire frees the lock
    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && !(acq_valid && acq_lock == rel_lock) |=> !held_o[$past(rel_lock)]);
endmodule

// File: rtl/lct_argmax.sv
module lct_argmax #(
    parameter int N_LOCKS = 4,
    parameter int ACC_W   = 16,
    localparam int LOCK_W = lct_pkg::idx_width(N_LOCKS)
) (
    input  logic [N_LOCKS-1:0][ACC_W-1:0] total_i,
    output logic [LOCK_W-1:0]             win_idx_o,
    output logic [ACC_W-1:0]              win_val_o
);
    always_comb begin
        win_idx_o = '0;
        win_val_o = total_i[0];
        for (int l = 1; l < N_LOCKS; l++) begin
            if (total_i[l] > win_val_o) begin
                win_idx_o = LOCK_W'(l);
                win_val_o = total_i[l];
            end
        end
    end
endmodule

// File: rtl/lock_limiter_tracker.sv
module lock_limiter_tracker #(
    parameter int N_THREADS = lct_pkg::DEF_THREADS,
    parameter int N_LOCKS   = lct_pkg::DEF_LOCKS,
    parameter int ACC_W     = lct_pkg::DEF_ACC_W,
    localparam int LOCK_W   = lct_pkg::idx_width(N_LOCKS),
    localparam int TID_W    = lct_pkg::idx_width(N_THREADS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_THREADS-1:0]          wait_valid,
    input  logic [N_THREADS*LOCK_W-1:0]   wait_lock,
    input  logic                          acq_valid,
    input  logic [LOCK_W-1:0]             acq_lock,
    input  logic [TID_W-1:0]              acq_tid,
    input  logic                          rel_valid,
    input  logic [LOCK_W-1:0]             rel_lock,
    input  logic                          tick,
    output logic [N_THREADS-1:0]          limiter_mask
);
    logic [N_LOCKS-1:0][ACC_W-1:0] total;
    logic [N_LOCKS-1:0]            held;
    logic [N_LOCKS-1:0][TID_W-1:0] owner;
    logic [LOCK_W-1:0]             win_idx;
    logic [ACC_W-1:0]              win_val;

    lct_wait_accum #(.N_THREADS(N_THREADS), .N_LOCKS(N_LOCKS), .ACC_W(ACC_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .wait_valid(wait_valid), .wait_lock(wait_lock),
        .tick(tick), .total_o(total));

    lct_holder_table #(.N_THREADS(N_THREADS), .N_LOCKS(N_LOCKS)) i_holders (
        .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_lock(acq_lock),
        .acq_tid(acq_tid), .rel_valid(rel_valid), .rel_lock(rel_lock),
        .held_o(held), .owner_o(owner));

    lct_argmax #(.N_LOCKS(N_LOCKS), .ACC_W(ACC_W)) i_argmax (
        .total_i(total), .win_idx_o(win_idx), .win_val_o(win_val));

    typedef struct packed {
        logic [N_THREADS-1:0] mask;
    } top_state_t;

    top_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.mask = '0;
            if ((win_val != '0) && held[win_idx])
                st_d.mask[owner[win_idx]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign limiter_mask = st_q.mask;

    // R5: at most one limiter thread
    a_r5_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(limiter_mask));
    // R8: without a tick the mask holds
    a_r8_stable_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(limiter_mask));
    // R4: an interval with no waiting yields no limiter
    a_r4_idle_interval: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (win_val == '0) |=> limiter_mask == '0);
    // R2: a held winner names its holder
    a_r2_holder_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (win_val != '0) && held[win_idx] |=> limiter_mask[$past(owner[win_idx])]);
endmodule

// File: tb/test_lock_limiter_tracker.sv
module test_lock_limiter_tracker;
    localparam int NT = 4;
    localparam int NL = 4;
    localparam int AW = 8;
    localparam int MAXV = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] wait_valid = '0;
    logic [7:0] wait_lock = '0;
    logic       acq_valid = 1'b0;
    logic [1:0] acq_lock = '0;
    logic [1:0] acq_tid = '0;
    logic       rel_valid = 1'b0;
    logic [1:0] rel_lock = '0;
    logic       tick = 1'b0;
    logic [3:0] limiter_mask;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R9";

    int m_acc[NL];
    int m_held[NL];
    int m_own[NL];
    int m_mask = 0;

    always #5 clk = ~clk;

    lock_limiter_tracker #(.N_THREADS(NT), .N_LOCKS(NL), .ACC_W(AW)) i_lock_limiter_tracker (
        .clk(clk), .rst_n(rst_n), .wait_valid(wait_valid), .wait_lock(wait_lock),
        .acq_valid(acq_valid), .acq_lock(acq_lock), .acq_tid(acq_tid),
        .rel_valid(rel_valid), .rel_lock(rel_lock), .tick(tick),
        .limiter_mask(limiter_mask));

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: mask actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // behavioural reference: advance by one cycle with the driven inputs
    task automatic model_step();
        int tot[NL];
        int best;
        int w;
        for (int l = 0; l < NL; l++) begin
            tot[l] = m_acc[l];
            for (int t = 0; t < NT; t++)
                if (wait_valid[t] && int'(wait_lock[2*t +: 2]) == l) tot[l]++;
            if (tot[l] > MAXV) tot[l] = MAXV;
        end
        if (tick) begin
            best = tot[0]; w = 0;
            for (int l = 1; l < NL; l++) if (tot[l] > best) begin best = tot[l]; w = l; end
            m_mask = (best > 0 && m_held[w] != 0) ? (1 << m_own[w]) : 0;
            for (int l = 0; l < NL; l++) m_acc[l] = 0;
        end else begin
            for (int l = 0; l < NL; l++) m_acc[l] = tot[l];
        end
        if (rel_valid) m_held[rel_lock] = 0;
        if (acq_valid) begin m_held[acq_lock] = 1; m_own[acq_lock] = acq_tid; end
    endtask

    task automatic cyc(input logic [3:0] wv, input logic [7:0] wl,
                       input logic av, input logic [1:0] al, input logic [1:0] at,
                       input logic rv, input logic [1:0] rl, input logic tk);
        wait_valid = wv; wait_lock = wl;
        acq_valid = av; acq_lock = al; acq_tid = at;
        rel_valid = rv; rel_lock = rl; tick = tk;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(cur_tag, int'(limiter_mask), m_mask);
    endtask

    task automatic waitn(input logic [3:0] wv, input logic [7:0] wl, input int n);
        for (int i = 0; i < n; i++) cyc(wv, wl, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic acquire(input logic [1:0] l, input logic [1:0] t);
        cyc(0, 0, 1, l, t, 0, 0, 0);
    endtask
    task automatic release_lock(input logic [1:0] l);
        cyc(0, 0, 0, 0, 0, 1, l, 0);
    endtask
    task automatic do_tick();
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) begin m_acc[l] = 0; m_held[l] = 0; m_own[l] = 0; end
        repeat (3) @(negedge clk);
        chk("R9 reset", int'(limiter_mask), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: an immediate tick after reset finds no holder and no totals
        cur_tag = "R9";
        do_tick();
        chk("R9 empty after reset", int'(limiter_mask), 0);

        // R2: thread 1 holds lock 2, which gathers more waiting than lock 0
        cur_tag = "R2";
        acquire(2, 1);
        waitn(4'b0101, 8'b00100010, 5);
        waitn(4'b1000, 8'b00000000, 3);
        do_tick();
        chk("R2 holder of busiest lock", int'(limiter_mask), 4'b0010);

        // R8: the mask holds across a quiet interval, then R4 clears it
        cur_tag = "R8";
        waitn(0, 0, 6);
        chk("R8 stable mid-interval", int'(limiter_mask), 4'b0010);
        cur_tag = "R4";
        do_tick();
        chk("R4 idle interval", int'(limiter_mask), 0);

        // R3: equal totals on locks 1 and 3, lower index wins
        cur_tag = "R3";
        release_lock(2);
        acquire(1, 0);
        acquire(3, 3);
        waitn(4'b0010, 8'b00000100, 2);
        waitn(4'b0100, 8'b00110000, 2);
        do_tick();
        chk("R3 tie to lower lock", int'(limiter_mask), 4'b0001);

        // R4: the winning lock has no holder
        cur_tag = "R4";
        waitn(4'b0010, 8'b00000000, 3);
        do_tick();
        chk("R4 unheld winner", int'(limiter_mask), 0);

        // R7: release in the tick cycle still names the releaser
        cur_tag = "R7";
        acquire(0, 2);
        waitn(4'b0001, 8'b00000000, 2);
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        chk("R7 release with tick", int'(limiter_mask), 4'b0100);
        waitn(4'b0001, 8'b00000000, 2);
        do_tick();
        chk("R7 released lock unheld", int'(limiter_mask), 0);

        // R7: acquire and release of one lock in the same cycle keep it held
        cyc(0, 0, 1, 2, 2, 1, 2, 0);
        waitn(4'b0001, 8'b00000010, 2);
        do_tick();
        chk("R7 acquire beats release", int'(limiter_mask), 4'b0100);
        release_lock(2);

        // R6: heavy waiting on lock 1 must not carry into the next interval
        cur_tag = "R6";
        waitn(4'b0110, 8'b00010100, 10);
        do_tick();
        chk("R6 first interval", int'(limiter_mask), 4'b0001);
        waitn(4'b0001, 8'b00000011, 2);
        do_tick();
        chk("R6 cleared totals", int'(limiter_mask), 4'b1000);

        // R1: waiting in the tick cycle itself decides the interval
        cur_tag = "R1";
        acquire(2, 1);
        waitn(4'b1000, 8'b11000000, 1);
        cyc(4'b0101, 8'b00100010, 0, 0, 0, 0, 0, 1);
        chk("R1 tick-cycle waiting counted", int'(limiter_mask), 4'b0010);

        // R10: both totals saturate, so lock 0 wins the tie over lock 1
        cur_tag = "R10";
        release_lock(1);
        acquire(1, 3);
        acquire(0, 2);
        waitn(4'b1111, 8'b01010101, 70);
        waitn(4'b1111, 8'b00000000, 65);
        do_tick();
        chk("R10 saturated tie", int'(limiter_mask), 4'b0100);

        // R5: random traffic compared with the model every cycle
        cur_tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] rv4;
            logic [7:0] rl8;
            rv4 = 4'($urandom);
            rl8 = 8'($urandom);
            cyc(rv4, rl8, ($urandom % 8) == 0, 2'($urandom), 2'($urandom),
                ($urandom % 8) == 0, 2'($urandom), ($urandom % 40) == 0);
            if (!$onehot0(limiter_mask)) chk("R5 onehot0", int'(limiter_mask), 0);
        end
        do_tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule